// File: doc/BRIEF.md
# SPI Multi-Word Burst Transmitter

This block is the transmit and receive engine of an SPI master. One chip-select burst can carry more bits than one 32-bit FIFO word holds. Software programs a length field with the total bit count minus one and then pulses `start_i`. The engine pulls 32-bit words from a transmit FIFO over a valid/ready handshake and shifts them out MSB-first on `mosi_o`. It generates `sclk_o` and keeps `cs_no` low for the whole burst.

The split between words is fixed. The first word contributes only the remainder of the length modulo the word width, taken from its low-order bits. Every later word contributes all 32 bits. A 48-bit burst therefore sends 16 bits from the first word and then 32 bits from the second. Bits arriving on `miso_i` are packed into receive words with the same split. Each receive word is pushed when its bit count is complete.

The clock idles low. MOSI changes while SCLK is low, and MISO is sampled on the SCLK rising edge. Each SCLK half period lasts `HALF_DIV` system clocks.

Top module: `spi_burst_tx`

## Requirements
- R1: After reset, and after an asynchronous reset in mid-burst, `cs_no` is 1 and `sclk_o`, `done_o`, `tx_ready_o`, `rx_valid_o` are 0.
- R2: With length field L, the first word supplies (L+1) mod 32 bits, or 32 bits when that remainder is 0 (L=0x020 sends 1 bit, L=0x021 sends 2 bits, L=47 sends 16 bits).
- R3: Every word after the first supplies all 32 of its bits.
- R4: Within a word that supplies n bits, bit n-1 is sent first and bit 0 last.
- R5: A burst with length field L produces exactly L+1 SCLK rising edges, for any L from 0 to 4095.
- R6: `cs_no` stays 0 from the start of the burst until after `done_o`, including across word boundaries.
- R7: When a word is needed and `tx_valid_i` is 0, SCLK stays low and `cs_no` stays low until a word is accepted.
- R8: Received bits form one receive word per transmit word, using the same bit counts. The first bit received is the most significant bit of the n received bits, and the word is right-aligned with zeros above. `rx_valid_o` pulses for one cycle per word.
- R9: `done_o` is high for exactly one cycle after the final SCLK falling edge, and `cs_no` returns to 1 in the next cycle.
- R10: Exactly floor(L/32)+1 words are accepted from the transmit FIFO per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst (sampled while idle) |
| burst_len_i | input | LEN_W | Total bit count minus one |
| tx_data_i | input | WORD_W | Transmit FIFO head word |
| tx_valid_i | input | 1 | Transmit FIFO not empty |
| tx_ready_o | output | 1 | Engine pops the head word this cycle when valid |
| rx_data_o | output | WORD_W | Completed receive word, right-aligned |
| rx_valid_o | output | 1 | Receive word push strobe |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
A MOSI bit is driven at least `HALF_DIV` clocks before its SCLK rising edge and is held through that edge. The bench therefore samples MOSI on the SCLK rising edge. It changes MISO on the SCLK falling edge, well ahead of the next sample point. `rx_valid_o` and `done_o` both rise one clock after the last SCLK-high tick of a word. `cs_no` rises exactly one clock after that. The bench reads all three at the falling system-clock edge and checks `cs_no` at the falling edge that follows the one where `done_o` was seen. Word pops are counted at the rising edge where valid and ready are both high, which matches the cycle the engine loads the word.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } burst_st_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (!run_i || tick_o)  cnt_q <= '0;
        else                        cnt_q <= cnt_q + CW'(1);
      end
      assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/spi_word_sizer.sv
module spi_word_sizer #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 12,
  localparam int unsigned IDX_W = $clog2(WORD_W),
  localparam int unsigned CNT_W = IDX_W + 1,
  localparam int unsigned WC_W  = LEN_W - IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             more_o
);
  logic [WC_W-1:0]  words_q;
  logic [CNT_W-1:0] cnt_q;

  // remainder goes first; a zero remainder means a full word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= '0;
      cnt_q   <= CNT_W'(WORD_W);
    end else if (start_i) begin
      words_q <= WC_W'(len_i[LEN_W-1:IDX_W]) + WC_W'(1);
      cnt_q   <= CNT_W'(len_i[IDX_W-1:0]) + CNT_W'(1);
    end else if (load_i) begin
      words_q <= words_q - WC_W'(1);
      cnt_q   <= CNT_W'(WORD_W);
    end
  end

  assign cnt_o  = cnt_q;
  assign more_o = (words_q != '0);

  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && (cnt_q <= CNT_W'(WORD_W)));
  a_r10_no_extra_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (words_q != '0));
  a_r3_later_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !start_i) |=> (cnt_q == CNT_W'(WORD_W)));
endmodule

// File: rtl/spi_shift_pair.sv
module spi_shift_pair #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o,
  output logic              last_o
);
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  bits_q;
  logic [CNT_W-1:0]  align;

  assign align = CNT_W'(WORD_W) - cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bits_q <= '0;
    end else if (load_i) begin
      tx_q   <= data_i << align;   // bit cnt-1 moves to the MSB
      rx_q   <= '0;
      bits_q <= cnt_i;
    end else begin
      if (sample_i) rx_q <= {rx_q[WORD_W-2:0], miso_i};
      if (shift_i) begin
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
        bits_q <= bits_q - CNT_W'(1);
      end
    end
  end

  assign mosi_o = tx_q[WORD_W-1];
  assign rx_o   = rx_q;
  assign last_o = (bits_q == CNT_W'(1));

  a_r4_shift_has_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (bits_q != '0));
  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && (shift_i || sample_i)));
endmodule

// File: rtl/spi_burst_tx.sv
module spi_burst_tx
  import spi_burst_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1;

  burst_st_e         state_q, state_d;
  logic              tick, run, load, sample, shift, last_bit, more;
  logic [CNT_W-1:0]  word_cnt;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] rx_data_q;
  logic              rx_valid_q;
  logic              kick;

  assign kick   = (state_q == ST_IDLE) && start_i;
  assign run    = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign load   = (state_q == ST_FETCH) && tx_valid_i;
  assign sample = (state_q == ST_LOW) && tick;
  assign shift  = (state_q == ST_HIGH) && tick;

  spi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  spi_word_sizer #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_sizer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(kick),
    .len_i  (burst_len_i),
    .load_i (load),
    .cnt_o  (word_cnt),
    .more_o (more)
  );

  spi_shift_pair #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .cnt_i   (word_cnt),
    .data_i  (tx_data_i),
    .sample_i(sample),
    .shift_i (shift),
    .miso_i  (miso_i),
    .mosi_o  (mosi_o),
    .rx_o    (rx_word),
    .last_o  (last_bit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_FETCH;
      ST_FETCH: if (tx_valid_i) state_d = ST_LOW;
      ST_LOW:   if (tick) state_d = ST_HIGH;
      ST_HIGH:  if (tick) begin
                  if (!last_bit)  state_d = ST_LOW;
                  else if (more)  state_d = ST_FETCH;
                  else            state_d = ST_DONE;
                end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rx_valid_q <= shift && last_bit;
      if (shift && last_bit) rx_data_q <= rx_word;
    end
  end

  assign tx_ready_o = (state_q == ST_FETCH);
  assign sclk_o     = (state_q == ST_HIGH);
  assign cs_no      = (state_q == ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;

  a_r6_sclk_under_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_cs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cs_no);
  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> (!sclk_o && !cs_no));
  a_r8_push_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !cs_no);
  a_r8_push_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: tb/spi_burst_tx_test.sv
module spi_burst_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int NV         = 7;

  localparam logic [11:0] V_LEN [NV] = '{12'd0, 12'd7, 12'd31, 12'h020, 12'h021, 12'd47, 12'd95};
  localparam logic [31:0] V_W [NV][3] = '{
    '{32'h0000_0001, 32'h0,          32'h0},
    '{32'hFFFF_FF5A, 32'h0,          32'h0},
    '{32'hDEAD_BEEF, 32'h0,          32'h0},
    '{32'hFFFF_FFFE, 32'h8000_0001,  32'h0},
    '{32'h0000_0002, 32'hCAFE_F00D,  32'h0},
    '{32'h1234_9876, 32'h0F0F_A5A5,  32'h0},
    '{32'h8421_0000, 32'h0000_1248,  32'hF00F_3CC3}
  };

  logic clk = 0, rst_n = 0, start = 0, miso = 0;
  logic [11:0] blen = '0;
  logic [31:0] tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid, sclk, mosi, cs_n, busy, done;

  int total = 0, bad = 0;
  logic [31:0] tx_words [128];
  int widx = 0, gap = 0, gap_cnt = 0;
  logic tx_en = 0;
  logic got_bits [4096];
  int edge_cnt = 0;
  logic [31:0] rx_got [128];
  int rx_cnt = 0, done_cnt = 0, cs_late_bad = 0, cs_gap_bad = 0;
  int stall_cyc = 0, stall_bad = 0;
  logic prev_done = 0, in_burst = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tx_valid = tx_en && (gap_cnt == 0);
  assign tx_data  = tx_words[widx[6:0]];

  spi_burst_tx #(.WORD_W(32), .LEN_W(12), .HALF_DIV(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .burst_len_i(blen),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .busy_o(busy), .done_o(done)
  );

  function automatic logic pat_bit(input int k);
    return ((k % 5) == 1) || ((k % 3) == 0);
  endfunction

  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      widx    <= widx + 1;
      gap_cnt <= gap;
    end else if (gap_cnt != 0) gap_cnt <= gap_cnt - 1;
  end

  always @(posedge sclk) begin
    if (edge_cnt < 4096) got_bits[edge_cnt] = mosi;
    edge_cnt++;
  end
  always @(negedge sclk) miso = pat_bit(edge_cnt);

  always @(negedge clk) begin
    if (rx_valid) begin
      if (rx_cnt < 128) rx_got[rx_cnt] = rx_data;
      rx_cnt++;
    end
    if (prev_done && !cs_n) cs_late_bad++;
    if (in_burst && cs_n) cs_gap_bad++;
    if (tx_ready && !tx_valid) begin
      stall_cyc++;
      if (sclk || cs_n) stall_bad++;
    end
    if (done) begin
      done_cnt++;
      in_burst = 0;
    end
    prev_done = done;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_burst(input logic [11:0] len, input int gap_v);
    int t;
    @(negedge clk);
    edge_cnt = 0; rx_cnt = 0; done_cnt = 0; cs_late_bad = 0; cs_gap_bad = 0;
    stall_cyc = 0; stall_bad = 0;
    widx = 0; gap = gap_v; miso = pat_bit(0); blen = len; tx_en = 1; start = 1;
    @(negedge clk);
    start = 0; in_burst = 1;
    t = 0;
    while (done_cnt == 0 && t < 40000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    tx_en = 0;
  endtask

  task automatic check_burst(input logic [11:0] len, input string tag);
    int nb, nw, first, err1, err2, rx_err, w, b, j, pos, n;
    logic [31:0] e;
    nb = int'(len) + 1;
    nw = int'(len) / 32 + 1;
    first = int'(len) % 32 + 1;
    chk(edge_cnt == nb, {"R5 sclk edges ", tag}, edge_cnt, nb);
    err1 = 0; err2 = 0;
    for (int i = 0; i < nb; i++) begin
      if (i < first) begin w = 0; b = first - 1 - i; end
      else begin j = i - first; w = 1 + j / 32; b = 31 - j % 32; end
      if (got_bits[i] !== tx_words[w][b]) begin
        if (w == 0) err1++; else err2++;
      end
    end
    chk(err1 == 0, {"R2 R4 first word bits ", tag}, err1, 0);
    chk(err2 == 0, {"R3 later word bits ", tag}, err2, 0);
    rx_err = 0; pos = 0;
    for (int k = 0; k < nw; k++) begin
      n = (k == 0) ? first : 32;
      e = '0;
      for (int i = 0; i < n; i++) begin
        e = {e[30:0], pat_bit(pos)};
        pos++;
      end
      if (k < rx_cnt && k < 128 && rx_got[k] !== e) rx_err++;
    end
    chk(rx_cnt == nw && rx_err == 0, {"R8 rx words ", tag}, rx_cnt * 1000 + rx_err, nw * 1000);
    chk(widx == nw, {"R10 words popped ", tag}, widx, nw);
    chk(done_cnt == 1 && cs_late_bad == 0, {"R9 done/cs release ", tag}, done_cnt * 100 + cs_late_bad, 100);
    chk(cs_gap_bad == 0, {"R6 cs held ", tag}, cs_gap_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) tx_words[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n && !sclk && !done && !tx_ready && !rx_valid, "R1 reset idle",
        {cs_n, sclk, done, tx_ready, rx_valid}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < 3; k++) tx_words[k] = V_W[v][k];
      run_burst(V_LEN[v], 0);
      check_burst(V_LEN[v], $sformatf("len=%0d", V_LEN[v]));
    end

    // R7 stall between words
    for (int k = 0; k < 3; k++) tx_words[k] = V_W[6][k] ^ 32'h5A5A_3C3C;
    run_burst(12'd95, 300);
    chk(stall_cyc > 100 && stall_bad == 0, "R7 stall holds sclk low, cs low", stall_bad, 0);
    check_burst(12'd95, "stalled");

    // R5 maximum length
    for (int k = 0; k < 128; k++) tx_words[k] = (k * 32'h0101_0101) ^ 32'hA5A5_0F0F;
    run_burst(12'hFFF, 0);
    check_burst(12'hFFF, "len=4095");

    // R1 reset in mid-burst
    tx_words[0] = 32'hFFFF_FFFF; tx_words[1] = 32'h1234_5678;
    @(negedge clk);
    blen = 12'd63; tx_en = 1; widx = 0; gap = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (40) @(negedge clk);
    rst_n = 0; in_burst = 0;
    #1;
    chk(cs_n && !sclk && !done && !tx_ready && !rx_valid, "R1 mid-burst reset",
        {cs_n, sclk, done, tx_ready, rx_valid}, 5'b10000);
    tx_en = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule